// File: doc/BRIEF.md
# Low-Memory SMM Window Guard

This block is a chipset-side guard for a fixed 128 KiB RAM window placed at physical address 0x30000. One byte-wide control register on a simple configuration bus exposes the guard to firmware. Firmware first probes for the feature with a query write. It then seals the window, and from that point only system-management-mode code can reach the RAM behind it. The seal cannot be undone by software; only a system reset clears it.

On the memory side, every request carries an address, read and write strobes, write data and a flag that marks system-management mode. Most requests are forwarded unchanged to the RAM port. The block answers a request itself only when all three hold: the window is sealed, the request falls inside the window, and the requester is not in system-management mode. In that case a read returns all ones and a write is swallowed. A strap input turns the whole feature off; with the strap low, the register never moves and the window stays open.

Top module: `smm_window_guard`

## Requirements
- R1: After a synchronous reset the control register at configuration offset 0x9C reads 0x00 and the window is open (every access reaches RAM).
- R2: With the strap high and the register at 0x00, writing 0xFF to offset 0x9C is a query; from the next cycle the register reads 0x01.
- R3: With the register at 0x00, a write of any value other than 0xFF is discarded: the register stays 0x00 and the window stays open.
- R4: With the register at 0x01, a write whose bit 1 is set (mask 0x02) seals the window; from the next cycle the register reads 0x02. A write with bit 1 clear leaves it at 0x01 and the window open.
- R5: Once sealed, the register ignores all writes and stays 0x02 with the window sealed until reset.
- R6: The window covers addresses 0x30000 to 0x4FFFF inclusive; accesses outside it always pass to RAM unchanged.
- R7: While sealed, a non-SMM read inside the window returns 0xFFFFFFFF without a RAM read strobe, and a non-SMM write inside the window raises no RAM write strobe.
- R8: While sealed, SMM accesses inside the window reach RAM with their read data returned unchanged; while open, all accesses reach RAM whatever the mode.
- R9: With the strap low, the register stays 0x00 whatever is written, including 0xFF, and the window is never sealed.
- R10: Configuration reads at offsets other than 0x9C return 0x00, and writes to other offsets leave the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| featureEn | input | 1 | Strap enabling the guard |
| cfgAddr | input | 8 | Configuration byte offset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWdata | input | 8 | Configuration write data |
| cfgRdata | output | 8 | Configuration read data |
| memAddr | input | 32 | Request address |
| memRd | input | 1 | Request read strobe |
| memWr | input | 1 | Request write strobe |
| memWdata | input | 32 | Request write data |
| memSmm | input | 1 | Requester is in system-management mode |
| memRdata | output | 32 | Read data returned to requester |
| ramAddr | output | 32 | RAM address |
| ramRd | output | 1 | RAM read strobe |
| ramWr | output | 1 | RAM write strobe |
| ramWdata | output | 32 | RAM write data |
| ramRdata | input | 32 | RAM read data |

## Verification
The assertions check the filtering on every cycle. Outside the window, strobes are forwarded unchanged. SMM traffic always passes. A blocked read yields all ones with no RAM strobe. The seal can never drop except on reset, and it can only rise after an accepted write with bit 1 set. They also check that the seal never rises while the strap is low. The order of the register states can only be shown by the bench's directed scenarios: discarded writes before the query, the 0x01 answer, the 0x02 answer after sealing, and the return to 0x00 after reset.

// File: rtl/smm_guard_pkg.sv
package smm_guard_pkg;
  localparam logic [7:0] CODE_QUERY = 8'hFF;
  localparam logic [7:0] CODE_READY = 8'h01;
  localparam logic [7:0] CODE_SEALED = 8'h02;
  localparam int SEAL_BIT = 1;

  typedef enum logic [1:0] {
    ST_OPEN,
    ST_ARMED,
    ST_SEALED
  } guard_state_t;

  typedef struct packed {
    logic sealOn;
  } guard_cmd_t;
endpackage

// File: rtl/smm_guard_ctrl.sv
module smm_guard_ctrl
  import smm_guard_pkg::*;
#(
  parameter int CFG_AW = 8,
  parameter logic [CFG_AW-1:0] REG_OFF = 'h9C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              featureEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic              cfgWe,
  input  logic [7:0]        cfgWdata,
  output logic [7:0]        cfgRdata,
  output guard_cmd_t        cmd
);
  guard_state_t state;
  logic regHit;
  logic regWr;
  logic [7:0] regVal;

  assign regHit = (cfgAddr == REG_OFF);
  assign regWr = regHit && cfgWe && featureEn;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_OPEN;
    end else if (regWr) begin
      case (state)
        ST_OPEN:  if (cfgWdata == CODE_QUERY) state <= ST_ARMED;
        ST_ARMED: if (cfgWdata[SEAL_BIT]) state <= ST_SEALED;
        default:  state <= state;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_ARMED:  regVal = CODE_READY;
      ST_SEALED: regVal = CODE_SEALED;
      default:   regVal = 8'h00;
    endcase
  end

  assign cfgRdata = regHit ? regVal : 8'h00;
  assign cmd.sealOn = (state == ST_SEALED);
endmodule

// File: rtl/smm_guard_path.sv
module smm_guard_path
  import smm_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'h30000,
  parameter logic [ADDR_W-1:0] WIN_SIZE = 'h20000
) (
  input  guard_cmd_t        cmd,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              memRd,
  input  logic              memWr,
  input  logic [DATA_W-1:0] memWdata,
  input  logic              memSmm,
  output logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramRd,
  output logic              ramWr,
  output logic [DATA_W-1:0] ramWdata,
  input  logic [DATA_W-1:0] ramRdata
);
  localparam logic [ADDR_W-1:0] WIN_LAST = WIN_BASE + WIN_SIZE - 1'b1;

  logic inWin;
  logic block;

  assign inWin = (memAddr >= WIN_BASE) && (memAddr <= WIN_LAST);
  assign block = cmd.sealOn && inWin && !memSmm;

  assign ramAddr  = memAddr;
  assign ramWdata = memWdata;
  assign ramRd    = memRd && !block;
  assign ramWr    = memWr && !block;
  assign memRdata = block ? '1 : ramRdata;
endmodule

// File: rtl/smm_window_guard.sv
module smm_window_guard
  import smm_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CFG_AW = 8,
  parameter logic [CFG_AW-1:0] REG_OFF = 'h9C,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'h30000,
  parameter logic [ADDR_W-1:0] WIN_SIZE = 'h20000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              featureEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic              cfgWe,
  input  logic [7:0]        cfgWdata,
  output logic [7:0]        cfgRdata,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              memRd,
  input  logic              memWr,
  input  logic [DATA_W-1:0] memWdata,
  input  logic              memSmm,
  output logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramRd,
  output logic              ramWr,
  output logic [DATA_W-1:0] ramWdata,
  input  logic [DATA_W-1:0] ramRdata
);
  guard_cmd_t cmd;

  smm_guard_ctrl #(.CFG_AW(CFG_AW), .REG_OFF(REG_OFF)) u_ctrl (
    .clk(clk), .rst(rst), .featureEn(featureEn),
    .cfgAddr(cfgAddr), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .cmd(cmd)
  );

  smm_guard_path #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)
  ) u_path (
    .cmd(cmd), .memAddr(memAddr), .memRd(memRd), .memWr(memWr),
    .memWdata(memWdata), .memSmm(memSmm), .memRdata(memRdata),
    .ramAddr(ramAddr), .ramRd(ramRd), .ramWr(ramWr),
    .ramWdata(ramWdata), .ramRdata(ramRdata)
  );
endmodule

// File: rtl/smm_guard_chk.sv
module smm_guard_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CFG_AW = 8,
  parameter logic [CFG_AW-1:0] REG_OFF = 'h9C,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'h30000,
  parameter logic [ADDR_W-1:0] WIN_SIZE = 'h20000
) (
  input logic              clk,
  input logic              rst,
  input logic              featureEn,
  input logic [CFG_AW-1:0] cfgAddr,
  input logic              cfgWe,
  input logic [7:0]        cfgWdata,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRd,
  input logic              memWr,
  input logic              memSmm,
  input logic [DATA_W-1:0] memRdata,
  input logic              ramRd,
  input logic              ramWr,
  input logic [DATA_W-1:0] ramRdata,
  input logic              sealOn
);
  localparam logic [ADDR_W-1:0] WIN_LAST = WIN_BASE + WIN_SIZE - 1'b1;
  logic inWin;
  assign inWin = (memAddr >= WIN_BASE) && (memAddr <= WIN_LAST);

  // R6
  outside_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !inWin |-> (ramRd == memRd) && (ramWr == memWr) && (memRdata == ramRdata));

  // R7
  blocked_read_chk: assert property (@(posedge clk) disable iff (rst)
    sealOn && inWin && !memSmm && memRd |-> !ramRd && (memRdata == '1));

  // R7
  blocked_write_chk: assert property (@(posedge clk) disable iff (rst)
    sealOn && inWin && !memSmm && memWr |-> !ramWr);

  // R8
  smm_pass_chk: assert property (@(posedge clk) disable iff (rst)
    memSmm |-> (ramRd == memRd) && (ramWr == memWr) && (memRdata == ramRdata));

  // R5
  seal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    sealOn |=> sealOn);

  // R4
  seal_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sealOn) |-> $past(cfgWe && (cfgAddr == REG_OFF) && cfgWdata[1]));

  // R9
  strap_off_chk: assert property (@(posedge clk) disable iff (rst)
    !featureEn && !sealOn |=> !sealOn);
endmodule

bind smm_window_guard smm_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_AW(CFG_AW), .REG_OFF(REG_OFF),
  .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)
) u_chk (
  .clk(clk), .rst(rst), .featureEn(featureEn), .cfgAddr(cfgAddr),
  .cfgWe(cfgWe), .cfgWdata(cfgWdata), .memAddr(memAddr), .memRd(memRd),
  .memWr(memWr), .memSmm(memSmm), .memRdata(memRdata), .ramRd(ramRd),
  .ramWr(ramWr), .ramRdata(ramRdata), .sealOn(cmd.sealOn)
);

// File: tb/sim_smm_window_guard.sv
`timescale 1ns/1ps
module sim_smm_window_guard;
  logic clk = 1'b0;
  logic rst;
  logic featureEn;
  logic [7:0] cfgAddr;
  logic cfgWe;
  logic [7:0] cfgWdata;
  logic [7:0] cfgRdata;
  logic [31:0] memAddr;
  logic memRd;
  logic memWr;
  logic [31:0] memWdata;
  logic memSmm;
  logic [31:0] memRdata;
  logic [31:0] ramAddr;
  logic ramRd;
  logic ramWr;
  logic [31:0] ramWdata;
  logic [31:0] ramRdata;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  assign ramRdata = ramAddr ^ 32'hA5C3_0000;

  smm_window_guard u0 (
    .clk(clk), .rst(rst), .featureEn(featureEn), .cfgAddr(cfgAddr),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .memAddr(memAddr), .memRd(memRd), .memWr(memWr), .memWdata(memWdata),
    .memSmm(memSmm), .memRdata(memRdata), .ramAddr(ramAddr), .ramRd(ramRd),
    .ramWr(ramWr), .ramWdata(ramWdata), .ramRdata(ramRdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic strap);
    @(negedge clk);
    featureEn = strap; rst = 1'b1;
    cfgWe = 1'b0; cfgAddr = 8'h00; cfgWdata = 8'h00;
    memRd = 1'b0; memWr = 1'b0; memSmm = 1'b0; memAddr = '0; memWdata = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic cfgWrite(input logic [7:0] off, input logic [7:0] val);
    @(negedge clk);
    cfgAddr = off; cfgWdata = val; cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic regIs(input string req, input logic [7:0] exp);
    cfgAddr = 8'h9C;
    #1;
    chk(req, {24'h0, cfgRdata}, {24'h0, exp});
  endtask

  // read at addr; checks returned data and RAM strobe
  task automatic memReadIs(input string req, input logic [31:0] a, input logic smm,
                           input logic expBlocked);
    memAddr = a; memSmm = smm; memRd = 1'b1; memWr = 1'b0;
    #1;
    chk(req, memRdata, expBlocked ? 32'hFFFF_FFFF : (a ^ 32'hA5C3_0000));
    chk(req, {31'h0, ramRd}, {31'h0, !expBlocked});
    memRd = 1'b0;
  endtask

  task automatic memWriteIs(input string req, input logic [31:0] a, input logic smm,
                            input logic expBlocked);
    memAddr = a; memSmm = smm; memWr = 1'b1; memRd = 1'b0; memWdata = 32'h1234_5678;
    #1;
    chk(req, {31'h0, ramWr}, {31'h0, !expBlocked});
    if (!expBlocked) chk(req, ramWdata, 32'h1234_5678);
    memWr = 1'b0;
  endtask

  task automatic tResetState;
    doReset(1'b1);
    regIs("R1", 8'h00);
    memReadIs("R1", 32'h0003_0000, 1'b0, 1'b0);
  endtask

  task automatic tDiscard;
    doReset(1'b1);
    cfgWrite(8'h9C, 8'h02);
    regIs("R3", 8'h00);
    cfgWrite(8'h9C, 8'hFE);
    regIs("R3", 8'h00);
    memReadIs("R3", 32'h0004_0000, 1'b0, 1'b0);
  endtask

  task automatic tQueryAndSeal;
    doReset(1'b1);
    cfgWrite(8'h9C, 8'hFF);
    regIs("R2", 8'h01);
    cfgWrite(8'h9C, 8'h01);
    regIs("R4", 8'h01);
    memReadIs("R4", 32'h0003_0000, 1'b0, 1'b0);
    memWriteIs("R8", 32'h0003_0004, 1'b0, 1'b0);
    cfgWrite(8'h9C, 8'h02);
    regIs("R4", 8'h02);
    memReadIs("R7", 32'h0003_0000, 1'b0, 1'b1);
  endtask

  task automatic tSealedWindow;
    doReset(1'b1);
    cfgWrite(8'h9C, 8'hFF);
    cfgWrite(8'h9C, 8'hFF);
    regIs("R4", 8'h02);
    memReadIs("R6", 32'h0002_FFFF, 1'b0, 1'b0);
    memReadIs("R6", 32'h0003_0000, 1'b0, 1'b1);
    memReadIs("R6", 32'h0004_FFFF, 1'b0, 1'b1);
    memReadIs("R6", 32'h0005_0000, 1'b0, 1'b0);
    memWriteIs("R7", 32'h0004_0000, 1'b0, 1'b1);
    memWriteIs("R6", 32'h0005_0010, 1'b0, 1'b0);
    memReadIs("R8", 32'h0004_FFFF, 1'b1, 1'b0);
    memWriteIs("R8", 32'h0003_1000, 1'b1, 1'b0);
  endtask

  task automatic tSticky;
    doReset(1'b1);
    cfgWrite(8'h9C, 8'hFF);
    cfgWrite(8'h9C, 8'h02);
    cfgWrite(8'h9C, 8'h00);
    regIs("R5", 8'h02);
    cfgWrite(8'h9C, 8'hFF);
    regIs("R5", 8'h02);
    memReadIs("R5", 32'h0003_8000, 1'b0, 1'b1);
    doReset(1'b1);
    regIs("R1", 8'h00);
    memReadIs("R1", 32'h0003_8000, 1'b0, 1'b0);
  endtask

  task automatic tStrapOff;
    doReset(1'b0);
    cfgWrite(8'h9C, 8'hFF);
    regIs("R9", 8'h00);
    cfgWrite(8'h9C, 8'h02);
    regIs("R9", 8'h00);
    memReadIs("R9", 32'h0003_0000, 1'b0, 1'b0);
    memWriteIs("R9", 32'h0004_0000, 1'b0, 1'b0);
  endtask

  task automatic tOtherOffset;
    doReset(1'b1);
    cfgWrite(8'h9D, 8'hFF);
    regIs("R10", 8'h00);
    cfgWrite(8'h9C, 8'hFF);
    cfgWrite(8'h9B, 8'h02);
    regIs("R10", 8'h01);
    cfgAddr = 8'h9B;
    #1;
    chk("R10", {24'h0, cfgRdata}, 32'h0);
  endtask

  initial begin
    rst = 1'b1;
    featureEn = 1'b1;
    cfgAddr = '0; cfgWe = 1'b0; cfgWdata = '0;
    memAddr = '0; memRd = 1'b0; memWr = 1'b0; memWdata = '0; memSmm = 1'b0;
    tResetState();
    tDiscard();
    tQueryAndSeal();
    tSealedWindow();
    tSticky();
    tStrapOff();
    tOtherOffset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule